// File: doc/BRIEF.md
# Load Merge Unit

This block forms the new value of a 64-bit general register after a fixed-point load-type operation. It takes the operand returned by memory, the value the destination register holds now, a size code and an operation code. From these it builds the word that is written back. The operand always lands in the low-order bits. The bits above it are filled in one of three ways: with copies of the operand's top bit, with zeros, or with the register's own upper bits.

The merge itself is combinational and is split into byte lanes. Each lane is fed from one of four sources: operand, sign fill, zero, or the old register value. The merged word is captured in an output register when the input is marked valid. The result therefore appears one clock after the request, together with its own valid flag.

Top module: `lmu_load_merge`

## Requirements
- R1: For sizes byte (size code 00, 8 bits), halfword (01, 16 bits) and integer (10, 32 bits), the low 8, 16 or 32 result bits equal the same bits of the memory operand, whatever the operation code.
- R2: Operation code 00 (signed load) on a size narrower than 64 bits fills every result bit above the operand width with the operand's most significant bit (bit 7, 15 or 31).
- R3: Operation code 01 (unsigned load) on a size narrower than 64 bits makes every result bit above the operand width zero.
- R4: Operation code 10 (insert) on a size narrower than 64 bits copies every result bit above the operand width unchanged from the current destination value.
- R5: Operation code 11 gives exactly the same result as operation code 00.
- R6: With size code 11 (long, 64 bits), the result equals the full memory operand for every operation code.
- R7: The result valid output equals the request valid input of the previous clock, and a result flagged valid is the merge of the inputs presented one clock earlier.
- R8: A clock with the request valid input low leaves the result data output unchanged.
- R9: While reset is asserted (active low), the result valid output is 0 and the result data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| size_sel | input | 2 | Operand size: 00 byte, 01 halfword, 10 integer, 11 long |
| op_sel | input | 2 | Operation: 00 signed load, 01 unsigned load, 10 insert, 11 as 00 |
| mem_data | input | 64 | Memory operand, right-justified |
| dst_data | input | 64 | Current destination register value |
| out_valid | output | 1 | Result qualifier, one clock after in_valid |
| out_data | output | 64 | New destination register value |

## Verification
The bench builds the block with its default parameters: a 64-bit register split into 8-bit lanes. With these values the four size codes map to operand widths of 8, 16, 32 and 64 bits, so the sign taps at bits 7, 15 and 31 and every lane boundary between operand and fill can be reached. Random operands hit both sign polarities for every size and operation pair, including the reserved operation code. Directed cases pin the all-ones and single-sign-bit patterns and idle clocks between requests.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_ULOAD  = 2'd1,
    OP_INSERT = 2'd2,
    OP_ALT    = 2'd3
  } op_e;

  // Source of one byte lane of the merged word
  typedef enum logic [1:0] {
    SRC_OPND = 2'd0,
    SRC_SIGN = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_DEST = 2'd3
  } lane_src_e;

  // The spare operation code behaves as a signed load
  function automatic op_e op_normalize(op_e op);
    return (op == OP_ALT) ? OP_LOAD : op;
  endfunction

endpackage

// File: rtl/lmu_lane_ctl.sv
module lmu_lane_ctl
  import lmu_pkg::*;
#(
  parameter int unsigned NLANES = 8
) (
  input  size_e                  size_sel,
  input  op_e                    op_sel,
  output lane_src_e [NLANES-1:0] lane_src
);

  localparam int unsigned CNT_W = $clog2(NLANES) + 1;

  op_e              op_eff;
  logic [CNT_W-1:0] live_lanes;

  assign op_eff     = op_normalize(op_sel);
  assign live_lanes = CNT_W'(1) << size_sel;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_comb begin
      if (CNT_W'(g) < live_lanes) begin
        lane_src[g] = SRC_OPND;
      end else begin
        case (op_eff)
          OP_ULOAD:  lane_src[g] = SRC_ZERO;
          OP_INSERT: lane_src[g] = SRC_DEST;
          default:   lane_src[g] = SRC_SIGN;
        endcase
      end
    end
  end

endmodule

// File: rtl/lmu_sign_pick.sv
module lmu_sign_pick
  import lmu_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NLANES = 8
) (
  input  logic [LANE_W*NLANES-1:0] opnd,
  input  size_e                    size_sel,
  output logic                     sign_bit
);

  localparam int unsigned NSIZES = $clog2(NLANES) + 1;

  logic [NSIZES-1:0] msb_tap;

  for (genvar k = 0; k < NSIZES; k++) begin : g_tap
    assign msb_tap[k] = opnd[(LANE_W << k) - 1];
  end

  assign sign_bit = msb_tap[size_sel];

endmodule

// File: rtl/lmu_lane_mux.sv
module lmu_lane_mux
  import lmu_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NLANES = 8
) (
  input  logic [LANE_W*NLANES-1:0] opnd,
  input  logic [LANE_W*NLANES-1:0] dest,
  input  logic                     sign_bit,
  input  lane_src_e [NLANES-1:0]   lane_src,
  output logic [LANE_W*NLANES-1:0] merged
);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_comb begin
      case (lane_src[g])
        SRC_OPND: merged[g*LANE_W +: LANE_W] = opnd[g*LANE_W +: LANE_W];
        SRC_SIGN: merged[g*LANE_W +: LANE_W] = {LANE_W{sign_bit}};
        SRC_ZERO: merged[g*LANE_W +: LANE_W] = '0;
        default:  merged[g*LANE_W +: LANE_W] = dest[g*LANE_W +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/lmu_out_reg.sv
module lmu_out_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] nxt_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      armed     <= 1'b1;
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt_data;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_valid == $past(in_valid));

  a_r7_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_valid) |-> out_data == $past(nxt_data));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(in_valid) |-> $stable(out_data));

endmodule

// File: rtl/lmu_load_merge.sv
module lmu_load_merge
  import lmu_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       size_sel,
  input  logic [1:0]       op_sel,
  input  logic [REG_W-1:0] mem_data,
  input  logic [REG_W-1:0] dst_data,
  output logic             out_valid,
  output logic [REG_W-1:0] out_data
);

  localparam int unsigned NLANES = REG_W / LANE_W;

  size_e                  size_q;
  op_e                    op_q;
  lane_src_e [NLANES-1:0] lane_src;
  logic                   sign_bit;
  logic [REG_W-1:0]       nxt_data;

  assign size_q = size_e'(size_sel);
  assign op_q   = op_e'(op_sel);

  lmu_lane_ctl #(.NLANES(NLANES)) u_ctl (
    .size_sel (size_q),
    .op_sel   (op_q),
    .lane_src (lane_src)
  );

  lmu_sign_pick #(.LANE_W(LANE_W), .NLANES(NLANES)) u_sign (
    .opnd     (mem_data),
    .size_sel (size_q),
    .sign_bit (sign_bit)
  );

  lmu_lane_mux #(.LANE_W(LANE_W), .NLANES(NLANES)) u_mux (
    .opnd     (mem_data),
    .dest     (dst_data),
    .sign_bit (sign_bit),
    .lane_src (lane_src),
    .merged   (nxt_data)
  );

  lmu_out_reg #(.W(REG_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .nxt_data  (nxt_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // Bit mask of the operand field for a size code, built bit by bit
  function automatic logic [REG_W-1:0] operand_mask(size_e s);
    logic [REG_W-1:0] m;
    int w;
    w = LANE_W << s;
    for (int i = 0; i < REG_W; i++) m[i] = (i < w);
    return m;
  endfunction

  // Top bit of the operand field, found by shifting it to bit 0
  function automatic logic field_top(logic [REG_W-1:0] v, size_e s);
    logic [REG_W-1:0] sh;
    sh = v >> ((LANE_W << s) - 1);
    return sh[0];
  endfunction

  logic [REG_W-1:0] fmask;
  logic [REG_W-1:0] sfill;
  assign fmask = operand_mask(size_q);
  assign sfill = field_top(mem_data, size_q) ? ~fmask : '0;

  a_r1_low_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((nxt_data ^ mem_data) & fmask) == '0);

  a_r2_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_q == OP_LOAD && size_q != SZ_LONG
      |-> (nxt_data & ~fmask) == sfill);

  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_q == OP_ULOAD && size_q != SZ_LONG
      |-> (nxt_data & ~fmask) == '0);

  a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_q == OP_INSERT && size_q != SZ_LONG
      |-> (nxt_data & ~fmask) == (dst_data & ~fmask));

  a_r5_alt_as_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_q == OP_ALT && size_q != SZ_LONG
      |-> (nxt_data & ~fmask) == sfill);

  a_r6_long_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_q == SZ_LONG |-> nxt_data == mem_data);

endmodule

// File: tb/test_lmu_load_merge.sv
module test_lmu_load_merge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic [1:0]  op_sel = 2'd0;
  logic [63:0] mem_data = '0;
  logic [63:0] dst_data = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lmu_load_merge i_lmu_load_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .op_sel(op_sel), .mem_data(mem_data), .dst_data(dst_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] low_mask(logic [1:0] sz);
    case (sz)
      2'd0: return 64'h0000_0000_0000_00FF;
      2'd1: return 64'h0000_0000_0000_FFFF;
      2'd2: return 64'h0000_0000_FFFF_FFFF;
      default: return {64{1'b1}};
    endcase
  endfunction

  function automatic logic [63:0] ref_merge(logic [1:0] sz, logic [1:0] op,
                                            logic [63:0] m, logic [63:0] d);
    logic [63:0] lo;
    logic        s;
    lo = low_mask(sz);
    if (sz == 2'd3) return m;
    s = (sz == 2'd0) ? m[7] : (sz == 2'd1) ? m[15] : m[31];
    case (op)
      2'd1:    return m & lo;
      2'd2:    return (m & lo) | (d & ~lo);
      default: return (m & lo) | (s ? ~lo : 64'h0);
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] sz, logic [1:0] op);
    if (sz == 2'd3) return "R6";
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic send(logic [1:0] sz, logic [1:0] op, logic [63:0] m, logic [63:0] d);
    logic [63:0] e;
    in_valid = 1'b1; size_sel = sz; op_sel = op; mem_data = m; dst_data = d;
    e = ref_merge(sz, op, m, d);
    @(negedge clk);
    check64("R7 valid", {63'h0, out_valid}, 64'h1);
    check64(tag_of(sz, op), out_data, e);
    if (sz != 2'd3) check64("R1 low field", out_data & low_mask(sz), m & low_mask(sz));
  endtask

  task automatic idle(logic [63:0] m, logic [63:0] d);
    logic [63:0] held;
    held = out_data;
    in_valid = 1'b0; size_sel = 2'd1; op_sel = 2'd2; mem_data = m; dst_data = d;
    @(negedge clk);
    check64("R7 idle valid", {63'h0, out_valid}, 64'h0);
    check64("R8 hold", out_data, held);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    in_valid = 1'b1; mem_data = {64{1'b1}};
    @(negedge clk);
    check64("R9 reset valid", {63'h0, out_valid}, 64'h0);
    check64("R9 reset data", out_data, 64'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: every size and operation with sign set and clear
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 4; op++) begin
        send(2'(sz), 2'(op), {64{1'b1}}, 64'hA5A5_5A5A_C3C3_3C3C);
        send(2'(sz), 2'(op), 64'h0123_4567_0000_7F7F, 64'hFFFF_0000_FFFF_0000);
        send(2'(sz), 2'(op), 64'h0000_0000_8000_8080, 64'h1357_9BDF_2468_ACE0);
      end
    end
    idle(64'hDEAD_BEEF_DEAD_BEEF, 64'h0);
    idle(64'h0, {64{1'b1}});

    // Random traffic with occasional idle clocks
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 7) == 0)
        idle({$urandom, $urandom}, {$urandom, $urandom});
      else
        send(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule